// File: doc/BRIEF.md
# Configuration Register Serial Slave

This block is the configuration front end of a two-channel acquisition front end. A host shifts fixed 24-bit frames into it over a four-wire serial bus (SPI mode 0, chip select active low). Each frame carries three bytes, most significant bit first: a command byte, then a register index, then a data byte. A write command stores the data byte in the indexed register. A read command returns the indexed register on the serial output while the data byte slot is clocked.

The register contents drive a set of named control outputs. Each amplifier channel has a gain code, an input selection, power-down and high-precision controls. Amplifier 1 also has a guard drive enable. The two modulators share a high-precision control and each has its own power-down. A raw bias/power byte is also provided. The serial clock, chip select and data input are asynchronous to the system clock. They pass through synchronizers, and all state lives in the system clock domain.

Top module: `cfgSpiSlave`

## Requirements
- R1: A frame is 24 serial clock rising edges while chip select is low, sampled MSB first: bits 23:16 command, bits 15:8 register index, bits 7:0 data.
- R2: Command 0x02 stores the data byte into the indexed register when the 24th rising edge is seen. Any command other than 0x02 never changes a register.
- R3: Command 0x03 presents the indexed register byte on `miso`, MSB first. The MSB is valid after the 16th rising edge, and the output advances one bit on each falling edge from the 17th onwards. For any other command, `miso` stays 0 during the data slot.
- R4: Register indices are: 0x00 identity (read-only, always reads 0x41), 0x01 amplifier 1, 0x02 amplifier 2, 0x03 modulator, 0x04 bias/power.
- R5: After reset, registers 0x01 to 0x04 read 0x00. Reserved bits are not stored and read 0: bit 3 of amplifier 2, and bits 7 and 3:0 of the modulator register. All bits of amplifier 1 and bias/power are stored.
- R6: In each amplifier register, bits 2:0 are the gain code (000 = 1x, doubling per step, 110 = 64x). The code 111 is reserved and raises that channel's `GainRsvd` output.
- R7: In each amplifier register, bits 5:4 select the input (11 both, 10 A only, 01 B only, 00 termination), bit 6 is high precision and bit 7 is power-down. Each drives its named output.
- R8: Bit 3 of amplifier 1 is active-low: `amp1GuardEn` is 1 when that bit is 0.
- R9: In the modulator register, bit 6 drives `modHp`, bit 5 drives `mod2Pdn` and bit 4 drives `mod1Pdn`. The bias/power register drives `pwrCfg` bit for bit.
- R10: Writes to index 0x00 or to any index above 0x04 change nothing. Reads of indices above 0x04 return 0x00.
- R11: If chip select rises before the 24th rising edge, the frame is dropped and no register changes.
- R12: `misoOe` is 1 only while the synchronized chip select is low, and `miso` is 0 whenever `misoOe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| csN | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial read data out |
| misoOe | output | 1 | Output enable for `miso` |
| amp1Gain | output | 3 | Amplifier 1 gain code |
| amp1GainRsvd | output | 1 | Amplifier 1 gain code is the reserved value |
| amp1Mux | output | 2 | Amplifier 1 input selection |
| amp1Hp | output | 1 | Amplifier 1 high precision |
| amp1Pdn | output | 1 | Amplifier 1 power-down |
| amp1GuardEn | output | 1 | Amplifier 1 guard drive enable |
| amp2Gain | output | 3 | Amplifier 2 gain code |
| amp2GainRsvd | output | 1 | Amplifier 2 gain code is the reserved value |
| amp2Mux | output | 2 | Amplifier 2 input selection |
| amp2Hp | output | 1 | Amplifier 2 high precision |
| amp2Pdn | output | 1 | Amplifier 2 power-down |
| modHp | output | 1 | Modulator high precision |
| mod1Pdn | output | 1 | Modulator 1 power-down |
| mod2Pdn | output | 1 | Modulator 2 power-down |
| pwrCfg | output | 8 | Bias/power option byte |

## Verification
The bench aborts frames after 20 and after 23 clocks. A design that committed early, or counted edges across frames, would corrupt a register there. It writes the identity index and an unmapped index, and it reads an unmapped index. A design with loose index decoding would alias these onto real registers or return stale data. Frames of all-ones data show whether reserved bits leak into readback, whether the active-low guard sense is inverted, and whether the reserved gain code is flagged. Random frames then check the read path, which must present the MSB before the 17th rising edge and shift only on falling edges; a design off by one edge returns each byte shifted by one bit.

// File: rtl/cfgSpiPkg.sv
package cfgSpiPkg;
  localparam int BYTE_W = 8;
  localparam int FRAME_BITS = 3 * BYTE_W;
  localparam int NUM_REGS = 5;

  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;
  localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;

  // storable bits per register index (reserved bits cleared)
  localparam logic [BYTE_W-1:0] KEEP_AMP1 = 8'hFF;
  localparam logic [BYTE_W-1:0] KEEP_AMP2 = 8'hF7;
  localparam logic [BYTE_W-1:0] KEEP_MOD  = 8'h70;
  localparam logic [BYTE_W-1:0] KEEP_PWR  = 8'hFF;

  typedef struct packed {
    logic              wrEn;
    logic              loadRd;
    logic              shiftOut;
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } strobeT;
endpackage

// File: rtl/cfgSpiCtrl.sv
module cfgSpiCtrl
  import cfgSpiPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclk,
  input  logic   csN,
  input  logic   mosi,
  output logic   csActive,
  output strobeT strb
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_ADDR_DONE = CNT_W'(FRAME_BITS - BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_LAST      = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SHIFT_MIN = CNT_W'(FRAME_BITS - BYTE_W);

  logic [SYNC_STAGES-1:0] sclkSr, csSr, mosiSr;
  logic sclkPrev, sclkS, mosiS, sclkRise, sclkFall;
  logic [CNT_W-1:0] bitCnt;
  logic [FRAME_BITS-1:0] shiftIn, shiftNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSr   <= '0;
      csSr     <= '1;
      mosiSr   <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSr   <= {sclkSr[SYNC_STAGES-2:0], sclk};
      csSr     <= {csSr[SYNC_STAGES-2:0], csN};
      mosiSr   <= {mosiSr[SYNC_STAGES-2:0], mosi};
      sclkPrev <= sclkS;
    end
  end

  assign sclkS    = sclkSr[SYNC_STAGES-1];
  assign mosiS    = mosiSr[SYNC_STAGES-1];
  assign csActive = ~csSr[SYNC_STAGES-1];
  assign sclkRise = csActive & sclkS & ~sclkPrev;
  assign sclkFall = csActive & ~sclkS & sclkPrev;
  assign shiftNext = {shiftIn[FRAME_BITS-2:0], mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      shiftIn <= '0;
    end else if (!csActive) begin
      bitCnt  <= '0;
    end else if (sclkRise && bitCnt != CNT_FULL) begin
      bitCnt  <= bitCnt + 1'b1;
      shiftIn <= shiftNext;
    end
  end

  always_comb begin
    strb.loadRd   = sclkRise && (bitCnt == CNT_ADDR_DONE) &&
                    (shiftNext[2*BYTE_W-1:BYTE_W] == OP_READ);
    strb.wrEn     = sclkRise && (bitCnt == CNT_LAST) &&
                    (shiftNext[3*BYTE_W-1:2*BYTE_W] == OP_WRITE);
    strb.shiftOut = sclkFall && (bitCnt > CNT_SHIFT_MIN);
    strb.addr     = (bitCnt == CNT_LAST) ? shiftNext[2*BYTE_W-1:BYTE_W]
                                         : shiftNext[BYTE_W-1:0];
    strb.data     = shiftNext[BYTE_W-1:0];
  end

  // R11: once chip select is seen high, no write can follow next cycle
  a_r11_abort_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> !strb.wrEn);
  // R1: the edge counter never passes one frame
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_FULL);
  // R3: read load and output shift never coincide
  a_r3_load_shift_apart: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRd |-> !strb.shiftOut);
  // R2: a write is a single-cycle strobe
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> !strb.wrEn);
endmodule

// File: rtl/cfgSpiRegs.sv
module cfgSpiRegs
  import cfgSpiPkg::*;
#(
  parameter logic [BYTE_W-1:0] VERSION_ID = 8'h41
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobeT      strb,
  input  logic        csActive,
  output logic        miso,
  output logic [BYTE_W-1:0] amp1Q,
  output logic [BYTE_W-1:0] amp2Q,
  output logic [BYTE_W-1:0] modQ,
  output logic [BYTE_W-1:0] pwrQ
);
  logic [BYTE_W-1:0] cfgQ [1:NUM_REGS-1];
  logic [BYTE_W-1:0] outShift, readByte;

  function automatic logic [BYTE_W-1:0] keepOf(input int idx);
    case (idx)
      1:       keepOf = KEEP_AMP1;
      2:       keepOf = KEEP_AMP2;
      3:       keepOf = KEEP_MOD;
      4:       keepOf = KEEP_PWR;
      default: keepOf = '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 1; i < NUM_REGS; i++) cfgQ[i] <= '0;
    end else if (strb.wrEn) begin
      for (int i = 1; i < NUM_REGS; i++)
        if (strb.addr == BYTE_W'(i)) cfgQ[i] <= strb.data & keepOf(i);
    end
  end

  always_comb begin
    readByte = '0;
    if (strb.addr == '0) readByte = VERSION_ID;
    for (int i = 1; i < NUM_REGS; i++)
      if (strb.addr == BYTE_W'(i)) readByte = cfgQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              outShift <= '0;
    else if (!csActive)     outShift <= '0;
    else if (strb.loadRd)   outShift <= readByte;
    else if (strb.shiftOut) outShift <= {outShift[BYTE_W-2:0], 1'b0};
  end

  assign miso  = csActive & outShift[BYTE_W-1];
  assign amp1Q = cfgQ[1];
  assign amp2Q = cfgQ[2];
  assign modQ  = cfgQ[3];
  assign pwrQ  = cfgQ[4];

  // R2: registers only move on a write strobe
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable({amp1Q, amp2Q, modQ, pwrQ}));
  // R10: writes to identity or unmapped indices leave everything alone
  a_r10_ignored_index: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn && (strb.addr == '0 || strb.addr >= BYTE_W'(NUM_REGS))
      |=> $stable({amp1Q, amp2Q, modQ, pwrQ}));
  // R4: a write to amplifier 1 stores the full data byte
  a_r4_amp1_store: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn && strb.addr == BYTE_W'(1) |=> amp1Q == $past(strb.data));
  // R12: serial output stays low while deselected
  a_r12_quiet_deselected: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> !miso);
endmodule

// File: rtl/cfgSpiSlave.sv
module cfgSpiSlave
  import cfgSpiPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] VERSION_ID = 8'h41
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       mosi,
  output logic       miso,
  output logic       misoOe,
  output logic [2:0] amp1Gain,
  output logic       amp1GainRsvd,
  output logic [1:0] amp1Mux,
  output logic       amp1Hp,
  output logic       amp1Pdn,
  output logic       amp1GuardEn,
  output logic [2:0] amp2Gain,
  output logic       amp2GainRsvd,
  output logic [1:0] amp2Mux,
  output logic       amp2Hp,
  output logic       amp2Pdn,
  output logic       modHp,
  output logic       mod1Pdn,
  output logic       mod2Pdn,
  output logic [7:0] pwrCfg
);
  strobeT strb;
  logic csActive;
  logic [BYTE_W-1:0] amp1Q, amp2Q, modQ, pwrQ;

  cfgSpiCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .csActive(csActive), .strb(strb)
  );

  cfgSpiRegs #(.VERSION_ID(VERSION_ID)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .csActive(csActive), .miso(miso),
    .amp1Q(amp1Q), .amp2Q(amp2Q), .modQ(modQ), .pwrQ(pwrQ)
  );

  assign misoOe       = csActive;
  assign amp1Gain     = amp1Q[2:0];
  assign amp1GainRsvd = &amp1Q[2:0];
  assign amp1Mux      = amp1Q[5:4];
  assign amp1Hp       = amp1Q[6];
  assign amp1Pdn      = amp1Q[7];
  assign amp1GuardEn  = ~amp1Q[3];
  assign amp2Gain     = amp2Q[2:0];
  assign amp2GainRsvd = &amp2Q[2:0];
  assign amp2Mux      = amp2Q[5:4];
  assign amp2Hp       = amp2Q[6];
  assign amp2Pdn      = amp2Q[7];
  assign modHp        = modQ[6];
  assign mod2Pdn      = modQ[5];
  assign mod1Pdn      = modQ[4];
  assign pwrCfg       = pwrQ;
endmodule

// File: tb/cfgSpiSlave_test.sv
module cfgSpiSlave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, misoOe, amp1GainRsvd, amp1Hp, amp1Pdn, amp1GuardEn;
  logic amp2GainRsvd, amp2Hp, amp2Pdn, modHp, mod1Pdn, mod2Pdn;
  logic [2:0] amp1Gain, amp2Gain;
  logic [1:0] amp1Mux, amp2Mux;
  logic [7:0] pwrCfg;

  int nChecks = 0, nErrors = 0;
  logic [7:0] mdl [0:4];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgSpiSlave uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .miso(miso), .misoOe(misoOe),
    .amp1Gain(amp1Gain), .amp1GainRsvd(amp1GainRsvd), .amp1Mux(amp1Mux),
    .amp1Hp(amp1Hp), .amp1Pdn(amp1Pdn), .amp1GuardEn(amp1GuardEn),
    .amp2Gain(amp2Gain), .amp2GainRsvd(amp2GainRsvd), .amp2Mux(amp2Mux),
    .amp2Hp(amp2Hp), .amp2Pdn(amp2Pdn),
    .modHp(modHp), .mod1Pdn(mod1Pdn), .mod2Pdn(mod2Pdn), .pwrCfg(pwrCfg)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] keepOf(input int idx);
    case (idx)
      1: keepOf = 8'hFF;
      2: keepOf = 8'hF7;
      3: keepOf = 8'h70;
      4: keepOf = 8'hFF;
      default: keepOf = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] ad);
    if (ad == 8'h00) expRead = 8'h41;
    else if (ad <= 8'h04) expRead = mdl[ad];
    else expRead = 8'h00;
  endfunction

  task automatic xfer(input logic [7:0] op, input logic [7:0] ad,
                      input logic [7:0] dt, input int nbits,
                      output logic [7:0] rd);
    logic [23:0] frame;
    frame = {op, ad, dt};
    rd = 8'h00;
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = frame[23-i];
      repeat (HALF) @(negedge clk);
      if (i >= 16) rd = {rd[6:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (HALF) @(negedge clk);
    if (nbits == 24 && op == 8'h02 && ad >= 8'h01 && ad <= 8'h04)
      mdl[ad] = dt & keepOf(int'(ad));
  endtask

  task automatic checkOuts(input string tag);
    chk({tag, " R6 amp1Gain"}, amp1Gain, mdl[1][2:0]);
    chk({tag, " R6 amp1GainRsvd"}, amp1GainRsvd, &mdl[1][2:0]);
    chk({tag, " R7 amp1 mux/hp/pdn"}, {amp1Pdn, amp1Hp, amp1Mux}, mdl[1][7:4]);
    chk({tag, " R8 amp1GuardEn"}, amp1GuardEn, !mdl[1][3]);
    chk({tag, " R6 amp2Gain"}, amp2Gain, mdl[2][2:0]);
    chk({tag, " R6 amp2GainRsvd"}, amp2GainRsvd, &mdl[2][2:0]);
    chk({tag, " R7 amp2 mux/hp/pdn"}, {amp2Pdn, amp2Hp, amp2Mux}, mdl[2][7:4]);
    chk({tag, " R9 modulator bits"}, {modHp, mod2Pdn, mod1Pdn}, mdl[3][6:4]);
    chk({tag, " R9 pwrCfg"}, pwrCfg, mdl[4]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] rd, op, ad, dt;
    for (int i = 0; i < 5; i++) mdl[i] = 8'h00;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R5 reset state, R12 deselected output
    checkOuts("reset R5");
    chk("R12 misoOe idle", misoOe, 0);
    chk("R12 miso idle", miso, 0);
    csN = 1'b0; repeat (6) @(negedge clk);
    chk("R12 misoOe selected", misoOe, 1);
    csN = 1'b1; repeat (6) @(negedge clk);
    chk("R12 misoOe released", misoOe, 0);

    // R4 identity read, R10 identity write ignored
    xfer(8'h03, 8'h00, 8'h00, 24, rd); chk("R4 identity read", rd, 8'h41);
    xfer(8'h02, 8'h00, 8'hA5, 24, rd);
    xfer(8'h03, 8'h00, 8'h00, 24, rd); chk("R10 identity write ignored", rd, 8'h41);

    // R5 reserved bits, R6 reserved gain, R8 guard sense
    for (int a = 1; a <= 4; a++) begin
      xfer(8'h02, 8'(a), 8'hFF, 24, rd);
      xfer(8'h03, 8'(a), 8'h00, 24, rd);
      chk("R5 readback all-ones", rd, keepOf(a));
    end
    checkOuts("all-ones R6 R8");
    xfer(8'h02, 8'h01, 8'h36, 24, rd);
    checkOuts("amp1 0x36 R7 R8");

    // R10 unmapped write/read
    xfer(8'h02, 8'h05, 8'h00, 24, rd);
    xfer(8'h02, 8'hFF, 8'h00, 24, rd);
    checkOuts("unmapped write R10");
    xfer(8'h03, 8'h07, 8'h00, 24, rd); chk("R10 unmapped read", rd, 0);

    // R11 aborted frames
    xfer(8'h02, 8'h04, 8'h12, 20, rd);
    xfer(8'h02, 8'h04, 8'h12, 23, rd);
    checkOuts("abort R11");
    xfer(8'h03, 8'h04, 8'h00, 24, rd); chk("R11 abort kept pwr", rd, mdl[4]);

    // R2 non-write command does nothing, R3 miso low for it
    xfer(8'h06, 8'h02, 8'h00, 24, rd); chk("R3 miso low non-read", rd, 0);
    checkOuts("other cmd R2");

    // random frames R1 R2 R3
    for (int n = 0; n < 50; n++) begin
      int sel;
      sel = $urandom_range(0, 3);
      op = (sel < 2) ? 8'h02 : (sel == 2) ? 8'h03 : 8'($urandom_range(0, 255));
      ad = 8'($urandom_range(0, 7));
      dt = 8'($urandom_range(0, 255));
      xfer(op, ad, dt, 24, rd);
      if (op == 8'h03) chk("R3 random read", rd, expRead(ad));
      else chk("R3 miso low non-read", rd, 0);
      checkOuts("random R1 R2");
    end

    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule